// File: doc/BRIEF.md
# Accumulator Stored-Program Core With Indirect Jumps

This block is a very small stored-program processor. It holds a 32-word by 32-bit internal store, a signed 32-bit accumulator, a 5-bit instruction-address register (`ci`) and a register that latches the fields of the instruction being executed. Each step first advances `ci` modulo 32 and fetches the word at the new address. It then executes that word. There are seven operations: indirect absolute jump, indirect relative jump, load negated, store, subtract, skip-if-negative and stop. The machine has no add operation and no conditional branch. Jump targets are always taken from a store word and never from the instruction itself.

A sequencer with four states controls the core:
- `ST_IDLE` moves to `ST_FETCH` when `run` is high.
- `ST_FETCH` always moves to `ST_EXEC`.
- `ST_EXEC` moves to `ST_HALT` on a stop instruction. Otherwise it returns to `ST_FETCH` while `run` is high, or to `ST_IDLE` when `run` is low.
- `ST_HALT` stays put while `run` is high and drops to `ST_IDLE` when `run` goes low.

Software loads a program through the debug port while the core is stopped. It raises `run`, waits for `halted`, and then reads the results back. The debug read port, `dbg_ci` and `dbg_acc` are visible at all times.

Top module: `baby_core`

## Requirements
- R1: Reset (active-low `rst_n`) clears `ci`, the accumulator and `halted` to zero and puts the core in `ST_IDLE`.
- R2: An instruction word carries its opcode in bits 15..13 and its operand address in bits 4..0. All other bits have no effect.
- R3: Each instruction takes two clocks. In `ST_FETCH`, `ci` becomes `(ci+1) mod 32` and the word at that new address is latched. In `ST_EXEC`, the latched instruction is carried out.
- R4: Opcode 000 sets `ci` to the low 5 bits of the addressed word. Opcode 001 adds those 5 bits to `ci`, modulo 32.
- R5: Opcode 010 loads the accumulator with the two's-complement negation of the addressed word.
- R6: Opcode 011 writes the accumulator into the addressed word.
- R7: Opcodes 100 and 101 both subtract the addressed word from the accumulator, modulo 2^32.
- R8: Opcode 110 ignores its address field. It adds one to `ci` when accumulator bit 31 is set, so the next instruction is skipped. Otherwise it does nothing.
- R9: Opcode 111 enters `ST_HALT`. `halted` then reads 1 and `ci` and the accumulator stay unchanged. This holds for as long as `run` stays high.
- R10: A debug write (`dbg_we`) takes effect at the clock edge only in `ST_IDLE` or `ST_HALT`. In `ST_FETCH` or `ST_EXEC` it leaves the store unchanged. `dbg_rdata` always shows the word at `dbg_addr` without delay.
- R11: In `ST_HALT`, `run` low clears `halted` at the next edge. Raising `run` from `ST_IDLE` resumes execution, fetching from `ci+1`.
- R12: If `run` is low when an instruction finishes, the core goes to `ST_IDLE` after completing that instruction. `ci` and the accumulator then hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Execute while high |
| halted | output | 1 | High in `ST_HALT` after a stop instruction |
| dbg_we | input | 1 | Debug store write enable |
| dbg_addr | input | 5 | Debug store address |
| dbg_wdata | input | 32 | Debug store write data |
| dbg_rdata | output | 32 | Store word at `dbg_addr` |
| dbg_ci | output | 5 | Current instruction-address register |
| dbg_acc | output | 32 | Accumulator |

## Verification
The hardest case to produce is a debug write that arrives while an instruction is in flight, because the write must be dropped without disturbing the store. The bench creates this by pulsing `dbg_we` a few clocks after raising `run` on a long program. It then reads the target word back after the stop. The other hard case is `run` falling between fetch and execute. The bench drops `run` one clock after starting, confirms that exactly one instruction completes, and then resumes. A second resume runs a jump to address 31, so the following fetch wraps `ci` to 0.

// File: rtl/baby_pkg.sv
package baby_pkg;
    localparam int OP_LSB = 13;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_JMP  = 3'd0,
        OP_JRP  = 3'd1,
        OP_LDN  = 3'd2,
        OP_STO  = 3'd3,
        OP_SUB  = 3'd4,
        OP_SUBX = 3'd5,
        OP_SKN  = 3'd6,
        OP_STP  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_HALT
    } state_e;
endpackage

// File: rtl/baby_store.sv
module baby_store #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/baby_exec.sv
module baby_exec
    import baby_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  op_e               op,
    input  logic [ADDR_W-1:0] ci,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    output logic [ADDR_W-1:0] ci_nxt,
    output logic [DATA_W-1:0] acc_nxt,
    output logic              st_en,
    output logic              stop
);
    always_comb begin
        ci_nxt  = ci;
        acc_nxt = acc;
        st_en   = 1'b0;
        stop    = 1'b0;
        unique case (op)
            OP_JMP:          ci_nxt  = operand[ADDR_W-1:0];
            OP_JRP:          ci_nxt  = ci + operand[ADDR_W-1:0];
            OP_LDN:          acc_nxt = -operand;
            OP_STO:          st_en   = 1'b1;
            OP_SUB, OP_SUBX: acc_nxt = acc - operand;
            OP_SKN:          ci_nxt  = ci + {{(ADDR_W-1){1'b0}}, acc[DATA_W-1]};
            OP_STP:          stop    = 1'b1;
        endcase
    end
endmodule

// File: rtl/baby_seq.sv
module baby_seq
    import baby_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    input  logic   stop_req,
    output state_e state,
    output logic   halted,
    output logic   dbg_open
);
    state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = run ? ST_FETCH : ST_IDLE;
            ST_FETCH: nxt = ST_EXEC;
            ST_EXEC:  nxt = stop_req ? ST_HALT : (run ? ST_FETCH : ST_IDLE);
            ST_HALT:  nxt = run ? ST_HALT : ST_IDLE;
        endcase
    end

    always_comb begin
        halted   = (state == ST_HALT);
        dbg_open = (state == ST_IDLE) || (state == ST_HALT);
    end
endmodule

// File: rtl/baby_core.sv
module baby_core
    import baby_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic              halted,
    input  logic              dbg_we,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic [DATA_W-1:0] dbg_rdata,
    output logic [ADDR_W-1:0] dbg_ci,
    output logic [DATA_W-1:0] dbg_acc
);
    state_e            state;
    logic              dbg_open, st_en, stop;
    logic [ADDR_W-1:0] ci, ci_inc, ci_nxt, pi_ea, rd_addr;
    logic [DATA_W-1:0] acc, acc_nxt, rd_word, wdata;
    logic [ADDR_W-1:0] waddr;
    logic              we;
    op_e               pi_op;

    assign ci_inc  = ci + 1'b1;
    assign rd_addr = (state == ST_FETCH) ? ci_inc : pi_ea;
    assign we      = (dbg_open && dbg_we) || ((state == ST_EXEC) && st_en);
    assign waddr   = dbg_open ? dbg_addr  : pi_ea;
    assign wdata   = dbg_open ? dbg_wdata : acc;

    baby_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .stop_req (stop),
        .state    (state),
        .halted   (halted),
        .dbg_open (dbg_open)
    );

    baby_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr_a (rd_addr),
        .rdata_a (rd_word),
        .raddr_b (dbg_addr),
        .rdata_b (dbg_rdata)
    );

    baby_exec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_exec (
        .op      (pi_op),
        .ci      (ci),
        .acc     (acc),
        .operand (rd_word),
        .ci_nxt  (ci_nxt),
        .acc_nxt (acc_nxt),
        .st_en   (st_en),
        .stop    (stop)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ci    <= '0;
            acc   <= '0;
            pi_ea <= '0;
            pi_op <= OP_JMP;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ci    <= ci_inc;
                    pi_ea <= rd_word[ADDR_W-1:0];
                    pi_op <= op_e'(rd_word[OP_LSB +: OP_W]);
                end
                ST_EXEC: begin
                    ci  <= ci_nxt;
                    acc <= acc_nxt;
                end
                ST_IDLE, ST_HALT: ;
            endcase
        end
    end

    assign dbg_ci  = ci;
    assign dbg_acc = acc;
endmodule

// File: rtl/baby_core_chk.sv
module baby_core_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              halted,
    input logic              dbg_we,
    input logic [ADDR_W-1:0] dbg_addr,
    input logic [DATA_W-1:0] dbg_wdata,
    input logic [DATA_W-1:0] dbg_rdata,
    input logic [ADDR_W-1:0] dbg_ci,
    input logic [DATA_W-1:0] dbg_acc
);
    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted && run |=> halted && $stable(dbg_ci) && $stable(dbg_acc));

    // R9
    stop_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $stable(dbg_ci) && $stable(dbg_acc));

    // R11
    halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !run |=> !halted);

    // R11
    release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halted) |-> $past(!run));

    // R10
    dbg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted && dbg_we |=> (dbg_addr != $past(dbg_addr)) || (dbg_rdata == $past(dbg_wdata)));
endmodule

bind baby_core baby_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .halted    (halted),
    .dbg_we    (dbg_we),
    .dbg_addr  (dbg_addr),
    .dbg_wdata (dbg_wdata),
    .dbg_rdata (dbg_rdata),
    .dbg_ci    (dbg_ci),
    .dbg_acc   (dbg_acc)
);

// File: tb/sim_baby_core.sv
`timescale 1ns/1ps
module sim_baby_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        halted;
    logic        dbg_we = 1'b0;
    logic [4:0]  dbg_addr = '0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic [4:0]  dbg_ci;
    logic [31:0] dbg_acc;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit mem_ok = 1'b0;

    always #2 clk = ~clk;

    baby_core u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .halted(halted),
        .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_rdata(dbg_rdata), .dbg_ci(dbg_ci), .dbg_acc(dbg_acc)
    );

    // behavioural reference: 0 idle, 1 fetch, 2 exec, 3 halt
    int          m_st = 0;
    int          m_ci = 0;
    logic [31:0] m_acc = '0;
    logic [31:0] m_pi = '0;
    logic [31:0] m_mem [32];
    bit          m_halt = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ci = 0; m_acc = '0; m_halt = 1'b0;
        end else begin
            case (m_st)
                0: begin
                    if (dbg_we) m_mem[dbg_addr] = dbg_wdata;
                    if (run) m_st = 1;
                end
                1: begin
                    m_ci = (m_ci + 1) % 32;
                    m_pi = m_mem[m_ci];
                    m_st = 2;
                end
                2: begin
                    int ea;
                    logic [31:0] w;
                    ea = int'(m_pi[4:0]);
                    w  = m_mem[ea];
                    case (int'(m_pi[15:13]))
                        0: m_ci = int'(w[4:0]);
                        1: m_ci = (m_ci + int'(w[4:0])) % 32;
                        2: m_acc = 32'd0 - w;
                        3: m_mem[ea] = m_acc;
                        4, 5: m_acc = m_acc - w;
                        6: if (m_acc[31]) m_ci = (m_ci + 1) % 32;
                        default: ;
                    endcase
                    if (int'(m_pi[15:13]) == 7) begin
                        m_st = 3; m_halt = 1'b1;
                    end else begin
                        m_st = run ? 1 : 0;
                    end
                end
                default: begin
                    if (dbg_we) m_mem[dbg_addr] = dbg_wdata;
                    if (!run) begin m_st = 0; m_halt = 1'b0; end
                end
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk("R3 ci", {27'd0, dbg_ci}, m_ci[31:0]);
            chk("R5/R7 acc", dbg_acc, m_acc);
            chk("R9 halted", {31'd0, halted}, {31'd0, m_halt});
            if (mem_ok) chk("R6/R10 store", dbg_rdata, m_mem[dbg_addr]);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // junk in ignored bits (R2)
    function automatic logic [31:0] mk(input int op, input int a);
        return {16'hA5A5, op[2:0], 8'hC3, a[4:0]};
    endfunction

    task automatic poke(input int a, input logic [31:0] d);
        dbg_we = 1'b1; dbg_addr = a[4:0]; dbg_wdata = d;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic peek(input string tag, input int a, input logic [31:0] exp);
        dbg_addr = a[4:0];
        #0.5;
        chk(tag, dbg_rdata, exp);
    endtask

    task automatic wait_halt();
        for (int i = 0; i < 200 && !halted; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ci reset", {27'd0, dbg_ci}, 32'd0);
        chk("R1 acc reset", dbg_acc, 32'd0);
        chk("R1 halted reset", {31'd0, halted}, 32'd0);

        for (int i = 0; i < 32; i++) poke(i, 32'd0);
        poke(1, mk(2, 20));
        poke(2, mk(4, 21));
        poke(3, mk(5, 21));
        poke(4, mk(3, 22));
        poke(5, mk(6, 9));
        poke(6, mk(7, 0));
        poke(7, mk(0, 23));
        poke(8, mk(7, 0));
        poke(9, mk(7, 0));
        poke(10, mk(1, 24));
        poke(11, mk(7, 0));
        poke(12, mk(7, 0));
        poke(13, mk(2, 22));
        poke(14, mk(6, 0));
        poke(15, mk(7, 0));
        poke(20, 32'd5);
        poke(21, 32'd3);
        poke(23, 32'd9);
        poke(24, 32'hFFFF_FFE2);
        poke(26, 32'h0000_1234);
        mem_ok = 1'b1;
        peek("R10 idle write", 20, 32'd5);

        run = 1'b1;
        repeat (4) @(negedge clk);
        poke(26, 32'hDEAD_BEEF);   // in flight: dropped (R10)
        wait_halt();
        chk("R9 stop halts", {31'd0, halted}, 32'd1);
        chk("R8 R4 final ci", {27'd0, dbg_ci}, 32'd15);
        chk("R5 final acc", dbg_acc, 32'd11);
        peek("R6 R7 stored diff", 22, 32'hFFFF_FFF5);
        peek("R10 write while running ignored", 26, 32'h0000_1234);

        poke(16, mk(0, 25));        // halted write, run high (R10)
        poke(25, 32'h0000_003F);
        poke(0, mk(7, 0));
        peek("R10 halted write", 25, 32'h0000_003F);
        chk("R9 still halted", {31'd0, halted}, 32'd1);
        run = 1'b0;
        @(negedge clk);
        chk("R11 halt released", {31'd0, halted}, 32'd0);
        run = 1'b1;
        wait_halt();
        chk("R4 R3 wrap ci", {27'd0, dbg_ci}, 32'd0);
        chk("R11 resumed and halted", {31'd0, halted}, 32'd1);

        run = 1'b0;
        @(negedge clk);
        poke(1, mk(2, 20));
        poke(2, mk(7, 0));
        run = 1'b1;
        @(negedge clk);
        run = 1'b0;
        repeat (5) @(negedge clk);
        chk("R12 one instruction then idle ci", {27'd0, dbg_ci}, 32'd1);
        chk("R12 acc after single step", dbg_acc, 32'hFFFF_FFFB);
        chk("R12 not halted", {31'd0, halted}, 32'd0);
        run = 1'b1;
        wait_halt();
        chk("R11 resume fetches ci+1", {27'd0, dbg_ci}, 32'd2);

        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule